// File: doc/BRIEF.md
# Queue-Ordered Lock Arbiter

This block sits beside a home memory and gives out a small set of lock variables to the nodes of a distributed machine. A node asks for a lock or gives one up by sending a request word. When the lock is free, the requester gets it at once. When the lock is held, the requester is linked onto the tail of that lock's waiting list through a per-node successor pointer, and it then receives nothing until its turn comes. A release from the holder follows the holder's successor pointer and sends a single grant message to that node. The other waiters are not disturbed, so spinning nodes create no traffic at the home.

Requests come in on a valid/ready stream. A request transfers on a rising edge where `req_valid` and `req_ready` are both high. Grants leave on a second valid/ready stream. A grant, once raised, holds its node and lock fields until `grant_ready` takes it. The unit has a single output slot, so `req_ready` is low whenever a grant is waiting. Each accepted request is handled in that same edge, and any grant or error it causes is visible right after the edge. The `req_err` pin is plain control and pulses for one cycle.

Top module: `lockq_mgr`

## Requirements
- R1: After reset every lock is free, `grant_valid` and `req_err` are low, and `req_ready` is high.
- R2: An acquire (`req_op`=0) for a free lock raises `grant_valid` right after the accepting edge, with `grant_node` equal to the requester and `grant_lock` equal to the lock.
- R3: An acquire for a held lock produces no grant. The requester is appended to the tail of that lock's waiting list.
- R4: A release (`req_op`=1) by the holder passes the lock to the waiters in the order their acquires arrived, one waiter per release.
- R5: A hand-off sends exactly one grant, addressed to the next waiter. No other waiter receives any message.
- R6: A release by the holder when no one is waiting frees the lock, produces no grant, and a following acquire is granted at once.
- R7: A release from a node that is not the holder, or a release for a free lock, changes nothing and raises `req_err` for one cycle right after the accepting edge.
- R8: An acquire from a node that already holds the lock or is already waiting for it is ignored. No grant, no error and no second list entry result.
- R9: While `grant_valid` is high and `grant_ready` is low, `req_ready` stays low and the grant fields stay stable. The grant retires on the edge where `grant_ready` is high.
- R10: The locks are independent. Requests for one lock never change the holder or the list of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request word present |
| req_ready | output | 1 | Unit can accept a request |
| req_op | input | 1 | 0 = acquire, 1 = release |
| req_node | input | NODE_W | Requesting node number |
| req_lock | input | LOCK_W | Lock variable index |
| grant_valid | output | 1 | Grant message present |
| grant_ready | input | 1 | Consumer takes the grant |
| grant_node | output | NODE_W | Node that now holds the lock |
| grant_lock | output | LOCK_W | Lock that was granted |
| req_err | output | 1 | One-cycle pulse for a rejected release |

## Verification
The embedded properties assume that `req_lock` names an existing lock and that the request fields matter only on an accepting edge. They also assume that no more than one request is taken per cycle, which the single request port guarantees. The bench drives a request only at a falling edge after it has seen `req_ready` high, drops `req_valid` after the accepting edge, and uses only lock indices below the lock count. Grant back-pressure is applied only in a directed test. That test holds `grant_ready` low and keeps `req_valid` high at the same time, so the refused requests are exercised.

// File: rtl/lockq_pkg.sv
package lockq_pkg;
  typedef enum logic {
    OP_ACQ = 1'b0,
    OP_REL = 1'b1
  } lockq_op_e;
endpackage

// File: rtl/lockq_slot.sv
module lockq_slot #(
  parameter int NUM_NODES = 8,
  parameter int NODE_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  logic              rel,
  input  logic [NODE_W-1:0] node,
  output logic              fire,
  output logic [NODE_W-1:0] fire_node,
  output logic              bad_rel
);
  logic                 busy;
  logic [NODE_W-1:0]    holder, tail;
  logic [NODE_W-1:0]    succ [NUM_NODES];
  logic [NUM_NODES-1:0] queued;

  logic is_holder, take_free, join_list, pass_on, free_up;

  always_comb begin
    is_holder = busy && (holder == node);
    take_free = hit && !rel && !busy;
    join_list = hit && !rel && busy && !queued[node];
    pass_on   = hit && rel && is_holder && (tail != node);
    free_up   = hit && rel && is_holder && (tail == node);
    bad_rel   = hit && rel && !is_holder;
    fire      = take_free || pass_on;
    fire_node = take_free ? node : succ[node];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      holder <= '0;
      tail   <= '0;
      queued <= '0;
    end else begin
      if (take_free) begin
        busy         <= 1'b1;
        holder       <= node;
        tail         <= node;
        queued[node] <= 1'b1;
      end
      if (join_list) begin
        tail         <= node;
        queued[node] <= 1'b1;
      end
      if (pass_on) begin
        holder       <= succ[node];
        queued[node] <= 1'b0;
      end
      if (free_up) begin
        busy         <= 1'b0;
        holder       <= '0;
        tail         <= '0;
        queued[node] <= 1'b0;
      end
    end
  end

  for (genvar n = 0; n < NUM_NODES; n++) begin : g_succ
    always_ff @(posedge clk) begin
      if (!rst_n)
        succ[n] <= '0;
      else if (join_list && tail == NODE_W'(n))
        succ[n] <= node;
    end
  end

  // R2
  granted_holder_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> busy && holder == $past(fire_node));
  // R6
  free_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> queued == '0);
  // R7
  bad_rel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_rel |=> $stable(holder) && $stable(tail) && $stable(busy));
  // R3
  busy_acq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && hit && !rel |=> busy && $stable(holder));
  // R10
  idle_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(busy) && $stable(holder) && $stable(tail));
endmodule

// File: rtl/lockq_out.sv
module lockq_out #(
  parameter int NODE_W = 3,
  parameter int LOCK_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [NODE_W-1:0] load_node,
  input  logic [LOCK_W-1:0] load_lock,
  input  logic              take,
  output logic              valid,
  output logic [NODE_W-1:0] node_q,
  output logic [LOCK_W-1:0] lock_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid  <= 1'b0;
      node_q <= '0;
      lock_q <= '0;
    end else if (load) begin
      valid  <= 1'b1;
      node_q <= load_node;
      lock_q <= load_lock;
    end else if (take) begin
      valid <= 1'b0;
    end
  end

  // R9
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !take |=> valid && $stable(node_q) && $stable(lock_q));
endmodule

// File: rtl/lockq_mgr.sv
module lockq_mgr #(
  parameter int NUM_NODES = 8,
  parameter int NUM_LOCKS = 2,
  localparam int NODE_W = (NUM_NODES > 1) ? $clog2(NUM_NODES) : 1,
  localparam int LOCK_W = (NUM_LOCKS > 1) ? $clog2(NUM_LOCKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_op,
  input  logic [NODE_W-1:0] req_node,
  input  logic [LOCK_W-1:0] req_lock,
  output logic              grant_valid,
  input  logic              grant_ready,
  output logic [NODE_W-1:0] grant_node,
  output logic [LOCK_W-1:0] grant_lock,
  output logic              req_err
);
  import lockq_pkg::*;

  logic                 accept, is_rel;
  logic [NUM_LOCKS-1:0] hit, fire, bad;
  logic [NODE_W-1:0]    fnode [NUM_LOCKS];
  logic                 any_fire, any_bad;
  logic [NODE_W-1:0]    sel_node;

  assign req_ready = !grant_valid;
  assign accept    = req_valid && req_ready;
  assign is_rel    = (lockq_op_e'(req_op) == OP_REL);

  for (genvar l = 0; l < NUM_LOCKS; l++) begin : g_lock
    assign hit[l] = accept && (req_lock == LOCK_W'(l));
    lockq_slot #(.NUM_NODES(NUM_NODES), .NODE_W(NODE_W)) u_slot (
      .clk(clk), .rst_n(rst_n), .hit(hit[l]), .rel(is_rel), .node(req_node),
      .fire(fire[l]), .fire_node(fnode[l]), .bad_rel(bad[l])
    );
  end

  always_comb begin
    sel_node = '0;
    for (int l = 0; l < NUM_LOCKS; l++)
      if (fire[l]) sel_node = sel_node | fnode[l];
    any_fire = |fire;
    any_bad  = |bad;
  end

  lockq_out #(.NODE_W(NODE_W), .LOCK_W(LOCK_W)) u_out (
    .clk(clk), .rst_n(rst_n), .load(any_fire), .load_node(sel_node),
    .load_lock(req_lock), .take(grant_ready), .valid(grant_valid),
    .node_q(grant_node), .lock_q(grant_lock)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) req_err <= 1'b0;
    else        req_err <= any_bad;
  end

  // R5
  single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fire));
  // R7
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> !$past(any_fire) && $past(req_op));
  // R9
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid && !grant_ready |=> !req_ready);
endmodule

// File: tb/tb_lockq_mgr.sv
module tb_lockq_mgr;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0, req_op = 1'b0, grant_ready = 1'b1;
  logic [2:0] req_node = '0;
  logic [0:0] req_lock = '0;
  logic       req_ready, grant_valid, req_err;
  logic [2:0] grant_node;
  logic [0:0] grant_lock;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic gv, ge;
  logic [2:0] gn;
  logic [0:0] gl;

  always #5 clk = ~clk;

  lockq_mgr dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_node(req_node), .req_lock(req_lock),
    .grant_valid(grant_valid), .grant_ready(grant_ready),
    .grant_node(grant_node), .grant_lock(grant_lock), .req_err(req_err)
  );

  // vector: {op, node[2:0], lock, exp_grant, exp_node[2:0], exp_err}
  localparam int NV = 17;
  localparam logic [9:0] VEC [NV] = '{
    {1'b0, 3'd3, 1'b0, 1'b1, 3'd3, 1'b0}, // R2 free lock
    {1'b0, 3'd1, 1'b0, 1'b0, 3'd0, 1'b0}, // R3 queued
    {1'b0, 3'd5, 1'b0, 1'b0, 3'd0, 1'b0}, // R3 queued
    {1'b0, 3'd1, 1'b0, 1'b0, 3'd0, 1'b0}, // R8 repeat waiter
    {1'b1, 3'd1, 1'b0, 1'b0, 3'd0, 1'b1}, // R7 non-holder
    {1'b0, 3'd2, 1'b1, 1'b1, 3'd2, 1'b0}, // R10 other lock
    {1'b1, 3'd3, 1'b0, 1'b1, 3'd1, 1'b0}, // R4 hand-off
    {1'b1, 3'd1, 1'b0, 1'b1, 3'd5, 1'b0}, // R4 R5 FIFO order
    {1'b1, 3'd5, 1'b0, 1'b0, 3'd0, 1'b0}, // R6 empty
    {1'b0, 3'd6, 1'b0, 1'b1, 3'd6, 1'b0}, // R6 regrant
    {1'b1, 3'd6, 1'b0, 1'b0, 3'd0, 1'b0}, // R6
    {1'b1, 3'd6, 1'b0, 1'b0, 3'd0, 1'b1}, // R7 free lock
    {1'b1, 3'd2, 1'b1, 1'b0, 3'd0, 1'b0}, // R10 frees L1
    {1'b0, 3'd4, 1'b0, 1'b1, 3'd4, 1'b0}, // R2
    {1'b0, 3'd4, 1'b0, 1'b0, 3'd0, 1'b0}, // R8 repeat holder
    {1'b1, 3'd4, 1'b0, 1'b0, 3'd0, 1'b0}, // R8 no duplicate
    {1'b0, 3'd0, 1'b0, 1'b1, 3'd0, 1'b0}  // R6
  };

  task automatic chk(string rq, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic send(logic op, logic [2:0] n, logic [0:0] l);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_op = op; req_node = n; req_lock = l;
    @(negedge clk);
    req_valid = 1'b0;
    gv = grant_valid; gn = grant_node; gl = grant_lock; ge = req_err;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 grant_valid", grant_valid, 0);
    chk("R1 req_ready", req_ready, 1);
    chk("R1 req_err", req_err, 0);

    for (int i = 0; i < NV; i++) begin
      logic [9:0] v;
      v = VEC[i];
      send(v[9], v[8:6], v[5]);
      chk($sformatf("vec%0d grant R2-R8", i), gv, v[4]);
      if (v[4]) begin
        chk($sformatf("vec%0d node R4", i), gn, v[3:1]);
        chk($sformatf("vec%0d lock R10", i), gl, v[5]);
      end
      chk($sformatf("vec%0d err R7", i), ge, v[0]);
    end

    // R9: back-pressure holds the grant and stalls requests
    send(1'b1, 3'd0, 1'b0);
    @(negedge clk);
    grant_ready = 1'b0;
    send(1'b0, 3'd7, 1'b1);
    chk("R9 grant raised", gv, 1);
    req_valid = 1'b1; req_op = 1'b0; req_node = 3'd2; req_lock = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R9 ready low", req_ready, 0);
      chk("R9 node stable", grant_node, 7);
    end
    req_valid = 1'b0;
    grant_ready = 1'b1;
    @(negedge clk);
    chk("R9 retired", grant_valid, 0);
    // stalled acquire from node 2 must not have been taken: release by 7 frees L1
    send(1'b1, 3'd7, 1'b1);
    chk("R9 no hidden request", gv, 0);
    send(1'b0, 3'd2, 1'b1);
    chk("R2 after stall", gv, 1);
    chk("R2 after stall node", gn, 2);

    // R1 again: reset clears held locks
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1 post reset valid", grant_valid, 0);
    send(1'b0, 3'd5, 1'b1);
    chk("R1 lock free after reset", gv, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule